// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers sixteen interrupt sources: eight external request pins, which are active low, and eight internal level lines, which are active high. Each external pin can be set to sense either a low level or a falling edge. Each pin can also be allowed to raise a wake-up request while the system is in a low-power state. The block keeps a pending bit for every source, applies a per-source enable mask and picks the winning source. A lower source number wins. The winner is reported as a vector code equal to four times the source number, so software can use the code directly as a branch-table offset.

Sources are numbered from 0 to 15 and alternate between the two kinds: external pin n is source 2n and internal line n is source 2n+1. Each external pin first passes through a two-flop synchronizer. It then goes through a two-state tracker:
- `LINE_HIGH` moves to `LINE_LOW` when the synchronized pin reads 0, and this transition is the falling edge.
- `LINE_LOW` moves back to `LINE_HIGH` when the synchronized pin reads 1.

A four-register port gives access to the block, with `bus_addr` selecting the register. The port has no wait states. Writes take effect on the clock edge. Reads are combinational and return zero while `bus_sel` is low.

Top module: `vpic_top`

## Requirements
- R1: Register 0 holds the pin configuration. For pin n, the edge-select bit is word bit 31-2n and the wake-enable bit is word bit 30-2n. Word bits 15:0 always read 0, and the values written to them are dropped.
- R2: When a pin's edge-select bit is 0, its source is pending exactly while the synchronized pin is low. The pending bit drops again once the pin returns high.
- R3: When a pin's edge-select bit is 1, a synchronized falling edge sets its pending bit, and the bit stays set after the pin rises. Writing register 2 with a 1 at bit 2n clears pin n's bit. A 0 written there leaves it unchanged.
- R4: If a falling edge and a write-1 clear for the same pin fall on the same clock edge, the pending bit ends up set.
- R5: Register 1 holds the enable mask: bit i set to 1 enables source i. Register 2 reads the pending bits in positions 15:0, and the mask does not affect them. Of the enabled pending sources, the one with the lowest number is chosen.
- R6: Register 3 is read-only. Its bits 31:24 hold the code, which is the chosen source number times 4, and its bits 23:0 read 0. After reset it reads 0x3C000000.
- R7: When no enabled source is pending, `cpu_irq` is 0 and the code is 0x3C. When source 15 alone is pending and enabled, the code is also 0x3C, but `cpu_irq` is 1.
- R8: `wake_req` is high whenever at least one pin is low and has its wake-enable bit set. The path is combinational, with no clock edge involved.
- R9: After reset, the configuration, mask and pending registers read 0 and `cpu_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_n | input | 8 | External request pins, active low |
| lvl_src | input | 8 | Internal level sources, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 cfg, 1 mask, 2 pending, 3 vector) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-up request to the power controller |

## Verification
A falling edge on an edge-mode pin can be latched in the same cycle as software's write-1 clear of that same pin's pending bit. The bench provokes this by holding the clearing write so that it lands on the edge where the tracker leaves `LINE_HIGH`. It then reads the pending register after the pin has risen again: the bit must still be set, and the vector must name that pin. Priority is also judged across several mask and source patterns, including the source-15 case where the code looks idle but `cpu_irq` is high.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int unsigned NPIN   = 8;
    localparam int unsigned NSRC   = 2 * NPIN;
    localparam int unsigned SRC_W  = $clog2(NSRC);
    localparam int unsigned CODE_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam logic [CODE_W-1:0] IDLE_CODE = CODE_W'((NSRC - 1) * 4);

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_MASK = 2'd1,
        REG_PEND = 2'd2,
        REG_VEC  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_HIGH = 1'b0,
        LINE_LOW  = 1'b1
    } line_state_e;
endpackage

// File: rtl/vpic_pin_front.sv
module vpic_pin_front
    import vpic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr_req,
    output logic pending
);
    logic        sync_a, sync_b;
    line_state_e st_q, st_nx;
    logic        fall;
    logic        latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pin_n;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINE_HIGH;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        fall  = 1'b0;
        unique case (st_q)
            LINE_HIGH: if (!sync_b) begin
                st_nx = LINE_LOW;
                fall  = 1'b1;
            end
            LINE_LOW:  if (sync_b) st_nx = LINE_HIGH;
            default:   st_nx = LINE_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      latch_q <= 1'b0;
        else if (edge_mode && fall)      latch_q <= 1'b1;
        else if (clr_req || !edge_mode)  latch_q <= 1'b0;
    end

    assign pending = edge_mode ? latch_q : !sync_b;

    // R3 R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> latch_q);

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && edge_mode && !clr_req) |=> latch_q);
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = IW'(N - 1);
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   irq_pin_n,
    input  logic [NPIN-1:0]   lvl_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq,
    output logic              wake_req
);
    logic [NPIN-1:0]   edge_en, wake_en;
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   eff;
    logic [NPIN-1:0]   pin_pend;
    logic [NPIN-1:0]   clr_req;
    logic [CODE_W-1:0] vec_q;
    logic              any_w;
    logic [SRC_W-1:0]  idx_w;
    logic              wr_cfg, wr_mask, wr_pend;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_cfg  = bus_sel && bus_wr && (sel == REG_CFG);
    assign wr_mask = bus_sel && bus_wr && (sel == REG_MASK);
    assign wr_pend = bus_sel && bus_wr && (sel == REG_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_en <= '0;
            wake_en <= '0;
        end else if (wr_cfg) begin
            for (int n = 0; n < NPIN; n++) begin
                edge_en[n] <= bus_wdata[DATA_W-1-2*n];
                wake_en[n] <= bus_wdata[DATA_W-2-2*n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata[NSRC-1:0];
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        assign clr_req[n] = wr_pend && bus_wdata[2*n];
        vpic_pin_front u_front (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (irq_pin_n[n]),
            .edge_mode (edge_en[n]),
            .clr_req   (clr_req[n]),
            .pending   (pin_pend[n])
        );
        assign pend[2*n]   = pin_pend[n];
        assign pend[2*n+1] = lvl_src[n];
    end

    assign eff = pend & mask_q;

    vpic_prio #(.N(NSRC), .IW(SRC_W)) u_prio (
        .req (eff),
        .any (any_w),
        .idx (idx_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q   <= IDLE_CODE;
            cpu_irq <= 1'b0;
        end else begin
            vec_q   <= any_w ? CODE_W'({idx_w, 2'b00}) : IDLE_CODE;
            cpu_irq <= any_w;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (sel)
                REG_CFG: begin
                    for (int n = 0; n < NPIN; n++) begin
                        bus_rdata[DATA_W-1-2*n] = edge_en[n];
                        bus_rdata[DATA_W-2-2*n] = wake_en[n];
                    end
                end
                REG_MASK: bus_rdata[NSRC-1:0] = mask_q;
                REG_PEND: bus_rdata[NSRC-1:0] = pend;
                REG_VEC:  bus_rdata[DATA_W-1 -: CODE_W] = vec_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign wake_req = |(~irq_pin_n & wake_en);

    // R1
    cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && sel == REG_CFG) |-> (bus_rdata[15:0] == 16'h0));

    // R5
    pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_w |-> eff[idx_w]);

    // R5
    pick_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_w |-> ((eff & ((NSRC'(1) << idx_w) - NSRC'(1))) == '0));

    // R6
    code_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q[1:0] == 2'b00);

    // R7
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (vec_q == IDLE_CODE));

    // R8
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (irq_pin_n != '1));
endmodule

// File: tb/vpic_top_test.sv
module vpic_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin_n = 8'hFF;
    logic [7:0]  lvl_src = 8'h00;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    logic        wake_req;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       tag;
        int          kind;   // 0 read data, 1 cpu_irq, 2 wake_req
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    vpic_top uut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .lvl_src(lvl_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .wake_req(wake_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, cpu_irq};
                    default: act = {31'b0, wake_req};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        sb.push_back(it);
        @(negedge clk); #1;
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [1:0] a, logic [31:0] exp, string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(tag, 0, exp);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R9 R6 R7 reset state
        rd_expect(2'd0, 32'h0, "R9 cfg after reset");
        rd_expect(2'd1, 32'h0, "R9 mask after reset");
        rd_expect(2'd2, 32'h0, "R9 pending after reset");
        rd_expect(2'd3, 32'h3C000000, "R6 vector after reset");
        push("R9 cpu_irq after reset", 1, 32'd0);

        // R1 layout and reserved bits
        wr(2'd0, 32'hFFFFFFFF);
        rd_expect(2'd0, 32'hFFFF0000, "R1 reserved low half reads zero");
        wr(2'd0, 32'h4400ABCD);  // wake pin0 (bit30), wake pin2 (bit26)
        rd_expect(2'd0, 32'h44000000, "R1 wake bit placement");

        // R8 wake path, checked before any clock edge follows the pin change
        irq_pin_n[2] = 1'b0; #1;
        checks++;
        if (wake_req !== 1'b1) begin
            fails++; $display("FAIL R8 wake comb actual=%b expected=1", wake_req);
        end
        push("R8 wake with enabled pin low", 2, 32'd1);
        irq_pin_n[2] = 1'b1; irq_pin_n[1] = 1'b0;
        push("R8 no wake from disabled pin", 2, 32'd0);
        irq_pin_n[1] = 1'b1;
        settle();

        // edge mode on pin0 (bit31) and pin3 (bit25), all sources enabled
        wr(2'd0, 32'h82000000);
        wr(2'd1, 32'h0000FFFF);
        rd_expect(2'd1, 32'h0000FFFF, "R5 mask readback");

        // R2 level mode on pin2 = source 4
        irq_pin_n[2] = 1'b0;
        settle();
        rd_expect(2'd2, 32'h00000010, "R2 level pending while low");
        rd_expect(2'd3, 32'h10000000, "R2 vector source 4");
        push("R2 cpu_irq level", 1, 32'd1);
        irq_pin_n[2] = 1'b1;
        settle();
        rd_expect(2'd2, 32'h0, "R2 level pending drops");
        rd_expect(2'd3, 32'h3C000000, "R7 idle code");
        push("R7 cpu_irq idle", 1, 32'd0);

        // R3 edge mode on pin0 = source 0
        irq_pin_n[0] = 1'b0;
        settle();
        irq_pin_n[0] = 1'b1;
        settle();
        rd_expect(2'd2, 32'h00000001, "R3 edge latched after rise");
        rd_expect(2'd3, 32'h00000000, "R3 vector source 0");
        wr(2'd2, 32'h0000FFFE);
        rd_expect(2'd2, 32'h00000001, "R3 write 0 keeps pending");
        wr(2'd2, 32'h00000001);
        settle();
        rd_expect(2'd2, 32'h0, "R3 write 1 clears pending");
        push("R3 cpu_irq after clear", 1, 32'd0);

        // R5 priority among internal sources 1 and 3
        lvl_src = 8'b0000_0011;
        settle();
        rd_expect(2'd3, 32'h04000000, "R5 source 1 wins");
        wr(2'd1, 32'h0000FFFD);
        settle();
        rd_expect(2'd3, 32'h0C000000, "R5 masked 1, source 3 wins");
        wr(2'd1, 32'h00000000);
        settle();
        rd_expect(2'd2, 32'h0000000A, "R5 pending ignores mask");
        push("R7 cpu_irq all masked", 1, 32'd0);
        rd_expect(2'd3, 32'h3C000000, "R7 code all masked");
        lvl_src = 8'b1000_0000;  // source 15
        wr(2'd1, 32'h0000FFFF);
        settle();
        rd_expect(2'd3, 32'h3C000000, "R7 source 15 code");
        push("R7 source 15 raises cpu_irq", 1, 32'd1);
        lvl_src = 8'h00;
        settle();

        // R4 edge on pin3 (source 6) coinciding with its clear
        irq_pin_n[3] = 1'b0;
        @(posedge clk); #1;            // first sync stage
        @(posedge clk); #1;            // second stage low: edge pending this cycle
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h00000040;
        @(posedge clk); #1;            // set and clear on the same edge
        bus_sel = 1'b0; bus_wr = 1'b0;
        irq_pin_n[3] = 1'b1;
        settle();
        rd_expect(2'd2, 32'h00000040, "R4 set wins over clear");
        rd_expect(2'd3, 32'h18000000, "R4 vector source 6");

        // R6 vector register is read-only
        wr(2'd3, 32'h00FFFFFF);
        rd_expect(2'd3, 32'h18000000, "R6 write to vector ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule